// File: doc/BRIEF.md
# Serial External Memory Bridge

This bridge lets a core whose memory port expects every access to finish in one cycle reach a word-wide external memory over only four serial pins. When the core raises a request, the bridge closes a glitch-free gate on the core clock. While the core is frozen it sends a serial frame and, for a load, shifts the returned word in. It then places that word on the core's read-data bus and opens the gate again. From the core's point of view the access took a single clock. The gated clock is also driven out on a pin, so an outside controller can follow the core's progress.

Each serial bit lasts two cycles of the free-running clock. The serial clock is low for the first cycle and high for the second. Output bits change when the serial clock falls, and input bits are sampled when it rises. Every field goes out most significant bit first.

The state machine has eight states:
- **IDLE**: no frame; the gate is open unless a request is present.
- **MODE**: one bit, 1 for a store and 0 for a load.
- **ADDR**: the word address.
- **WDATA**: store data.
- **BYTEN**: byte enables.
- **TURN**: three bits of turnaround while the memory fetches.
- **RDATA**: load data is shifted in.
- **WAKE**: chip select is released and the gate is opened for one core edge.

The transitions are:
- IDLE→MODE on a request.
- MODE→ADDR.
- ADDR→WDATA for a store, or ADDR→TURN for a load.
- WDATA→BYTEN.
- BYTEN→WAKE.
- TURN→RDATA.
- RDATA→WAKE, which also loads the read-data bus.
- WAKE→IDLE.

Top module: `sermem_bridge`

## Requirements
- R1: While reset is active and right after it, cs_n is 1, sclk is 0 and cpu_rdata is 0. core_clk keeps running during reset.
- R2: A store produces exactly 47 sclk rising edges while cs_n is low. The bits on mosi, in order, are: 1, then address bits 9..0, then data bits 31..0, then byte-enable bits 3..0. Enable bit i covers data bits 8i+7..8i.
- R3: A load produces exactly 46 sclk rising edges while cs_n is low. The bits on mosi are 0, then address bits 9..0, then 35 zero bits. The last 32 bits of miso, sampled at sclk rising edges and most significant bit first, appear on cpu_rdata at the core edge that ends the access. The 3 bits after the address are ignored.
- R4: While cs_n stays low, mosi changes only at a falling edge of sclk. While cs_n is high, sclk is low.
- R5: core_clk has no rising edge while cs_n is low. From the core edge at which a request is first presented to the next core edge takes 96 clk cycles for a store and 94 for a load.
- R6: Between two frames, cs_n stays high for at least two clk cycles (one serial period), even for back-to-back requests.
- R7: cpu_rdata changes only when a load frame ends. A store leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | free-running clock |
| rst_n | input | 1 | asynchronous reset, active low |
| cpu_req | input | 1 | core requests an access |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 10 | word address |
| cpu_wdata | input | 32 | store data |
| cpu_be | input | 4 | byte enables for a store |
| cpu_rdata | output | 32 | last loaded word |
| core_clk | output | 1 | gated core clock, also driven to a pin |
| sclk | output | 1 | serial clock |
| cs_n | output | 1 | chip select, active low |
| mosi | output | 1 | serial data to memory |
| miso | input | 1 | serial data from memory |

## Verification
The checks assume that the request lines come from logic clocked by core_clk. They may change only after a core edge and must settle before clk falls. They also assume that miso changes only at sclk falling edges. The bench drives the core side one time unit after each core_clk rising edge. Its memory model updates miso only at sclk falling edges. During turnaround and outside the data window it holds miso at 1, so a wrong capture window cannot go unnoticed.

// File: rtl/sxm_pkg.sv
`timescale 1ns/1ps
package sxm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MODE,
        ST_ADDR,
        ST_WDATA,
        ST_BYTEN,
        ST_TURN,
        ST_RDATA,
        ST_WAKE
    } sxm_state_e;
endpackage

// File: rtl/sxm_clkgate.sv
`timescale 1ns/1ps
module sxm_clkgate (
    input  logic clk,
    input  logic open_i,
    output logic gclk
);
    logic en_lat;

    // enable follows open_i only while clk is low, so gclk cannot glitch
    always_latch begin
        if (!clk) en_lat = open_i;
    end

    assign gclk = clk & en_lat;
endmodule

// File: rtl/sxm_seq.sv
`timescale 1ns/1ps
module sxm_seq
    import sxm_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 32,
    parameter int BE_W     = DATA_W / 8,
    parameter int TURN_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_req,
    input  logic cpu_we,
    output logic frame_o,
    output logic phase_o,
    output logic in_mode_o,
    output logic is_wr_o,
    output logic load_o,
    output logic shift_o,
    output logic sample_o,
    output logic commit_o,
    output logic open_o
);
    localparam int MAXLEN = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
    localparam int CW     = $clog2(MAXLEN);

    sxm_state_e    state, state_n;
    logic          ph, ph_n;
    logic [CW-1:0] cnt, cnt_n;
    logic          is_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ph    <= 1'b0;
            cnt   <= '0;
            is_wr <= 1'b0;
        end else begin
            state <= state_n;
            ph    <= ph_n;
            cnt   <= cnt_n;
            if (state == ST_IDLE && cpu_req) is_wr <= cpu_we;
        end
    end

    always_comb begin
        state_n = state;
        ph_n    = ph;
        cnt_n   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (cpu_req) begin
                    state_n = ST_MODE;
                    ph_n    = 1'b0;
                    cnt_n   = '0;
                end
            end
            ST_WAKE: state_n = ST_IDLE;
            default: begin
                ph_n = ~ph;
                if (ph) begin
                    if (cnt != '0) begin
                        cnt_n = cnt - 1'b1;
                    end else begin
                        unique case (state)
                            ST_MODE: begin
                                state_n = ST_ADDR;
                                cnt_n   = CW'(ADDR_W - 1);
                            end
                            ST_ADDR: begin
                                state_n = is_wr ? ST_WDATA : ST_TURN;
                                cnt_n   = is_wr ? CW'(DATA_W - 1) : CW'(TURN_CYC - 1);
                            end
                            ST_WDATA: begin
                                state_n = ST_BYTEN;
                                cnt_n   = CW'(BE_W - 1);
                            end
                            ST_TURN: begin
                                state_n = ST_RDATA;
                                cnt_n   = CW'(DATA_W - 1);
                            end
                            default: state_n = ST_WAKE;
                        endcase
                    end
                end
            end
        endcase
    end

    always_comb begin
        frame_o   = (state != ST_IDLE) && (state != ST_WAKE);
        phase_o   = ph;
        in_mode_o = (state == ST_MODE);
        is_wr_o   = is_wr;
        load_o    = (state == ST_IDLE) && cpu_req;
        shift_o   = ph && ((state == ST_ADDR) || (state == ST_WDATA) || (state == ST_BYTEN));
        sample_o  = !ph && (state == ST_RDATA);
        commit_o  = ph && (state == ST_RDATA) && (cnt == '0);
        open_o    = (state == ST_WAKE) || ((state == ST_IDLE) && !cpu_req);
    end
endmodule

// File: rtl/sxm_shift.sv
`timescale 1ns/1ps
module sxm_shift #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    parameter int BE_W   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic              sample,
    input  logic              commit,
    input  logic              frame,
    input  logic              in_mode,
    input  logic              is_wr,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [BE_W-1:0]   cpu_be,
    input  logic              miso,
    output logic              mosi,
    output logic [DATA_W-1:0] rdata
);
    localparam int TX_W = ADDR_W + DATA_W + BE_W;

    logic [TX_W-1:0]   tx;
    logic [DATA_W-1:0] rx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx    <= '0;
            rx    <= '0;
            rdata <= '0;
        end else begin
            if (load)
                tx <= cpu_we ? {cpu_addr, cpu_wdata, cpu_be}
                             : {cpu_addr, {(DATA_W + BE_W){1'b0}}};
            else if (shift)
                tx <= {tx[TX_W-2:0], 1'b0};
            if (sample) rx <= {rx[DATA_W-2:0], miso};
            if (commit) rdata <= rx;
        end
    end

    always_comb begin
        if (!frame)       mosi = 1'b0;
        else if (in_mode) mosi = is_wr;
        else              mosi = tx[TX_W-1];
    end
endmodule

// File: rtl/sermem_bridge.sv
`timescale 1ns/1ps
module sermem_bridge #(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 32,
    parameter int TURN_CYC = 3,
    localparam int BE_W    = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [BE_W-1:0]   cpu_be,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              core_clk,
    output logic              sclk,
    output logic              cs_n,
    output logic              mosi,
    input  logic              miso
);
    logic frame, phase, in_mode, is_wr, load, shift, sample, commit, open_s;

    sxm_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W), .TURN_CYC(TURN_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .frame_o(frame), .phase_o(phase), .in_mode_o(in_mode), .is_wr_o(is_wr),
        .load_o(load), .shift_o(shift), .sample_o(sample), .commit_o(commit),
        .open_o(open_s)
    );

    sxm_shift #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)
    ) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .shift(shift), .sample(sample),
        .commit(commit), .frame(frame), .in_mode(in_mode), .is_wr(is_wr),
        .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_be(cpu_be), .miso(miso), .mosi(mosi), .rdata(cpu_rdata)
    );

    sxm_clkgate u_gate (
        .clk(clk), .open_i(open_s | !rst_n), .gclk(core_clk)
    );

    assign sclk = frame & phase;
    assign cs_n = ~frame;
endmodule

// File: rtl/sermem_bridge_chk.sv
`timescale 1ns/1ps
module sermem_bridge_chk #(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 32,
    parameter int TURN_CYC = 3,
    localparam int BE_W    = DATA_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic [BE_W-1:0]   cpu_be,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              core_clk,
    input logic              sclk,
    input logic              cs_n,
    input logic              mosi,
    input logic              miso
);
    localparam int WR_LEN = 1 + ADDR_W + DATA_W + BE_W;
    localparam int RD_LEN = 1 + ADDR_W + TURN_CYC + DATA_W;

    logic       sclk_d;
    logic       mode_q;
    logic [7:0] nrise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            mode_q <= 1'b0;
            nrise  <= '0;
        end else begin
            sclk_d <= sclk;
            if (cs_n) nrise <= '0;
            else if (sclk && !sclk_d) begin
                nrise <= nrise + 1'b1;
                if (nrise == '0) mode_q <= mosi;
            end
        end
    end

    AST_WR_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cs_n) && mode_q) |-> (nrise == 8'(WR_LEN))); // R2
    AST_RD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cs_n) && !mode_q) |-> (nrise == 8'(RD_LEN))); // R3
    AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n) && !$fell(sclk)) |-> $stable(mosi)); // R4
    AST_SCLK_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk); // R4
    AST_NO_CORE_EDGE: assert property (@(posedge core_clk) disable iff (!rst_n)
        cs_n); // R5
    AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> cs_n); // R6
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cpu_rdata) |-> ($rose(cs_n) && !mode_q)); // R7
endmodule

bind sermem_bridge sermem_bridge_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TURN_CYC(TURN_CYC)
) u_chk (.*);

// File: tb/sermem_bridge_test.sv
`timescale 1ns/1ps
module sermem_bridge_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [9:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [3:0]  cpu_be = '0;
    logic [31:0] cpu_rdata;
    logic        core_clk, sclk, cs_n, mosi;
    logic        miso = 1'b1;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    realtime t_last;
    realtime gap;
    int core_edges = 0;

    always #2.5 clk = ~clk;

    sermem_bridge uut (.*);

    // ---------------- memory model ----------------
    logic [31:0] mem [1024];
    logic [46:0] fr, last_fr;
    int          n = 0, last_n = 0;
    logic        mmode = 1'b0;
    logic [9:0]  maddr = '0;

    always @(negedge cs_n) begin
        fr = '0;
        n  = 0;
    end
    always @(posedge sclk) if (!cs_n) begin
        fr = {fr[45:0], mosi};
        n  = n + 1;
        if (n == 1)  mmode = mosi;
        if (n == 11) maddr = fr[9:0];
    end
    always @(negedge sclk) begin
        if (!cs_n && !mmode && n >= 14 && n < 46) miso = mem[maddr][45-n];
        else                                        miso = 1'b1;
    end
    always @(posedge cs_n) if (rst_n) begin
        last_n  = n;
        last_fr = fr;
        if (mmode && n == 47)
            for (int i = 0; i < 4; i++)
                if (fr[i]) mem[fr[45:36]][8*i +: 8] = fr[4+8*i +: 8];
    end

    // ---------------- pin monitors ----------------
    int   bad_mosi = 0, bad_park = 0, hrun = 0, min_gap = 1000;
    logic pmosi = 1'b0, pcs = 1'b1;
    bit   seen_frame = 0;
    always @(negedge clk) if (rst_n) begin
        if (!cs_n && !pcs && mosi !== pmosi && sclk) bad_mosi++;
        if (cs_n && sclk) bad_park++;
        if (cs_n) hrun++;
        else begin
            if (pcs && seen_frame && hrun < min_gap) min_gap = hrun;
            seen_frame = 1;
            hrun = 0;
        end
        pmosi = mosi;
        pcs   = cs_n;
    end
    always @(posedge core_clk) core_edges++;

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [9:0] a, input logic [31:0] d,
                          input logic [3:0] be);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_be = be;
        @(posedge core_clk);
        gap = $realtime - t_last;
        t_last = $realtime;
        #1;
    endtask

    task automatic idle_cycle();
        cpu_req = 1'b0;
        @(posedge core_clk);
        t_last = $realtime;
        #1;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        repeat (4) @(posedge clk);
        #1;
        chk("R1 cs_n in reset", cs_n, 1);
        chk("R1 sclk in reset", sclk, 0);
        chk("R1 rdata in reset", cpu_rdata, 0);
        chk("R1 core_clk runs in reset", core_edges >= 3, 1);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge core_clk);
        t_last = $realtime;
        #1;
        chk("R1 cs_n after reset", cs_n, 1);
        chk("R1 rdata after reset", cpu_rdata, 0);
    endtask

    task automatic t_write_full();
        access(1'b1, 10'h3A5, 32'hDEADBEEF, 4'hF);
        chk("R2 write frame length", last_n, 47);
        chk("R2 write frame bits", last_fr, {1'b1, 10'h3A5, 32'hDEADBEEF, 4'hF});
        chk("R5 write stall cycles", int'(gap / 5.0), 96);
        chk("R7 rdata kept over write", cpu_rdata, 0);
        idle_cycle();
    endtask

    task automatic t_read_back();
        access(1'b0, 10'h3A5, 32'h0, 4'h0);
        chk("R3 read frame length", last_n, 46);
        chk("R3 read frame bits", last_fr, {2'b00, 10'h3A5, 35'h0});
        chk("R3 read data", cpu_rdata, 32'hDEADBEEF);
        chk("R5 read stall cycles", int'(gap / 5.0), 94);
        idle_cycle();
    endtask

    task automatic t_partial();
        access(1'b1, 10'h3A5, 32'h11223344, 4'b0101);
        chk("R2 byte-enable field", last_fr[3:0], 4'b0101);
        chk("R7 rdata kept over partial write", cpu_rdata, 32'hDEADBEEF);
        idle_cycle();
        access(1'b0, 10'h3A5, 32'h0, 4'h0);
        chk("R3 merged read data", cpu_rdata, 32'hDE22BE44);
        idle_cycle();
    endtask

    task automatic t_bounds_b2b();
        access(1'b1, 10'h000, 32'h00000001, 4'hF);
        access(1'b1, 10'h3FF, 32'h80000000, 4'hF);
        chk("R2 top address field", last_fr[45:36], 10'h3FF);
        access(1'b0, 10'h3FF, 32'h0, 4'h0);
        chk("R3 read top address", cpu_rdata, 32'h80000000);
        chk("R5 back-to-back read stall", int'(gap / 5.0), 94);
        access(1'b0, 10'h000, 32'h0, 4'h0);
        chk("R3 read address zero", cpu_rdata, 32'h00000001);
        idle_cycle();
        chk("R6 minimum cs_n gap", min_gap >= 2, 1);
    endtask

    task automatic t_pattern();
        access(1'b0, 10'h155, 32'h0, 4'h0);
        chk("R3 pattern read", cpu_rdata, 32'hA5A55A5A);
        chk("R3 pattern address bits", last_fr[44:35], 10'h155);
        idle_cycle();
        repeat (3) idle_cycle();
        chk("R7 rdata held while idle", cpu_rdata, 32'hA5A55A5A);
        chk("R4 mosi only on sclk fall", bad_mosi, 0);
        chk("R4 sclk parked low", bad_park, 0);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        mem[10'h155] = 32'hA5A55A5A;
        t_reset();
        t_write_full();
        t_read_back();
        t_partial();
        t_bounds_b2b();
        t_pattern();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #200us;
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule